// File: doc/BRIEF.md
# Serial Receive Channel with Threshold FIFO

This block is one receive channel of an asynchronous serial port. A programmable 16-bit rate divisor, split into a low byte and a high byte, produces a sampling strobe at sixteen times the bit rate. The receiver watches the idle-high line for a falling edge and confirms the start bit at its centre. It then collects five to eight data bits, least significant first, plus an optional parity bit and a stop bit. Each finished character is stored together with its parity-error and framing-error flags in a sixteen-entry first-in first-out buffer.

A host reads the oldest entry from the read port and pops it with a one-cycle read strobe. The interrupt line rises when the buffer's occupancy reaches one of four selectable thresholds. The host can therefore let several characters build up before it services the channel. A data-ready flag, a sticky overrun flag and the oldest entry's error flags form the line status. A clear input empties the buffer and leaves the rate and format settings alone.

Top module: `uart_rx_fifo`

## Requirements
- R1: The sampling strobe fires once every N clock cycles, where N = {div_hi, div_lo}, and a divisor of 0 acts as 1. One bit lasts 16 strobes.
- R2: A low level on the idle line starts a character only if the line is still low 8 strobes later, at the centre of the start bit. Otherwise the receiver returns to idle and stores nothing.
- R3: Data bits arrive least significant bit first. word_len selects the count: 0=5, 1=6, 2=7, 3=8 bits. rd_data holds the character right-aligned, with the unused upper bits zero.
- R4: When par_en=1, one parity bit follows the data. par_odd=0 expects even parity over data and parity bit, and par_odd=1 expects odd parity. A mismatch stores rd_perr=1 with that character. When par_en=0, rd_perr is 0.
- R5: A stop bit sampled low at its centre stores rd_ferr=1 with that character.
- R6: The buffer holds up to 16 characters in arrival order. rd_data, rd_perr and rd_ferr show the oldest entry, and rd_en pops one entry when the buffer is not empty. fifo_count gives the occupancy, and it changes by at most one per cycle except on a clear.
- R7: A character that completes while 16 entries are held is discarded and sets overrun. overrun stays set until a cycle with lsr_rd=1.
- R8: trig_sel selects the threshold: 0=1, 1=4, 2=8, 3=14 entries. irq is high exactly while fifo_count is at or above the selected threshold.
- R9: data_ready is high exactly while fifo_count is non-zero.
- R10: A cycle with fifo_clr=1 empties the buffer on the next clock edge. The divisor and format inputs keep working, so the next character is received normally.
- R11: After reset, fifo_count=0, data_ready=0, irq=0 and overrun=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial input line, idle high |
| div_lo | input | 8 | Low byte of the rate divisor |
| div_hi | input | 8 | High byte of the rate divisor |
| word_len | input | 2 | Data bit count code (5 to 8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| trig_sel | input | 2 | Interrupt threshold select |
| fifo_clr | input | 1 | Empty the buffer |
| rd_en | input | 1 | Pop the oldest entry |
| lsr_rd | input | 1 | Line status read, clears overrun |
| rd_data | output | 8 | Oldest character |
| rd_perr | output | 1 | Parity error flag of the oldest character |
| rd_ferr | output | 1 | Framing error flag of the oldest character |
| fifo_count | output | 5 | Buffer occupancy |
| data_ready | output | 1 | Buffer not empty |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Occupancy at or above threshold |

## Verification
The receiver gets asymmetric byte values at 5, 7 and 8 data bits. These show whether bit order, right alignment and data length are correct. Parity cases send matching and flipped parity bits under both even and odd parity, and a low stop bit exercises the framing flag. A four-clock low pulse tells a start that was checked at mid-bit apart from one taken on the bare edge. Sending at divisors 3, 256 and 0 shows whether both divisor bytes and the zero case reach the strobe. Filling the buffer one character at a time while all four thresholds are swept separates the threshold decode from the occupancy count. A seventeenth character then checks discard, stickiness and clear-on-read of overrun.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int SW   = $clog2(OVS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic [7:0]    div_lo,
  input  logic [7:0]    div_hi,
  input  logic [1:0]    word_len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic [1:0]    trig_sel,
  input  logic          fifo_clr,
  input  logic          rd_en,
  input  logic          lsr_rd,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic [CW-1:0] fifo_count,
  output logic          data_ready,
  output logic          overrun,
  output logic          irq
);
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_t;

  logic [15:0] div, div_cnt;
  logic        tick;
  assign div  = {div_hi, div_lo};
  assign tick = (div_cnt == 16'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= (div == 16'd0) ? 16'd0 : div - 16'd1;
    else           div_cnt <= div_cnt - 16'd1;

  logic [1:0] rx_q;
  logic       rx_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_q <= 2'b11;
    else        rx_q <= {rx_q[0], rxd};
  assign rx_s = rx_q[1];

  rx_state_t   st;
  logic [SW-1:0] scnt;
  logic [2:0]  bcnt;
  logic [7:0]  shr;
  logic        acc, perr_q;
  logic        bit_end;
  logic [2:0]  last_bit;
  assign bit_end  = (scnt == SW'(OVS - 1));
  assign last_bit = {1'b0, word_len} + 3'd4;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; scnt <= '0; bcnt <= '0; shr <= '0; acc <= 1'b0; perr_q <= 1'b0;
    end else if (tick) begin
      case (st)
        S_IDLE: begin
          scnt <= '0;
          if (!rx_s) st <= S_START;
        end
        S_START:
          if (scnt == SW'(HALF - 1)) begin
            scnt <= '0; bcnt <= '0; acc <= 1'b0; perr_q <= 1'b0;
            st <= rx_s ? S_IDLE : S_DATA;
          end else scnt <= scnt + 1'b1;
        S_DATA: begin
          scnt <= bit_end ? '0 : scnt + 1'b1;
          if (bit_end) begin
            shr  <= {rx_s, shr[7:1]};
            acc  <= acc ^ rx_s;
            bcnt <= bcnt + 3'd1;
            if (bcnt == last_bit) st <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: begin
          scnt <= bit_end ? '0 : scnt + 1'b1;
          if (bit_end) begin
            perr_q <= acc ^ rx_s ^ par_odd;
            st     <= S_STOP;
          end
        end
        S_STOP: begin
          scnt <= bit_end ? '0 : scnt + 1'b1;
          if (bit_end) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end

  logic       push, full, do_push, do_pop;
  logic [7:0] rx_byte;
  assign push    = tick && (st == S_STOP) && bit_end;
  assign rx_byte = shr >> (2'd3 - word_len);
  assign full    = (fifo_count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = rd_en && (fifo_count != '0);

  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk)
    if (do_push && !fifo_clr) mem[wp] <= {!rx_s, perr_q, rx_byte};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; fifo_count <= '0;
    end else if (fifo_clr) begin
      wp <= '0; rp <= '0; fifo_count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fifo_count <= fifo_count + 1'b1;
        2'b01:   fifo_count <= fifo_count - 1'b1;
        default: fifo_count <= fifo_count;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            overrun <= 1'b0;
    else if (push && full) overrun <= 1'b1;
    else if (lsr_rd)       overrun <= 1'b0;

  logic [CW-1:0] level;
  always_comb
    case (trig_sel)
      2'd0:    level = CW'(1);
      2'd1:    level = CW'(4);
      2'd2:    level = CW'(8);
      default: level = CW'(14);
    endcase

  assign rd_data    = mem[rp][7:0];
  assign rd_perr    = mem[rp][8];
  assign rd_ferr    = mem[rp][9];
  assign data_ready = (fifo_count != '0);
  assign irq        = (fifo_count >= level);
endmodule

module uart_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clr,
  input logic          lsr_rd,
  input logic [1:0]    trig_sel,
  input logic [CW-1:0] count,
  input logic          overrun,
  input logic          data_ready,
  input logic          irq
);
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fifo_clr) |-> (count == $past(count) || count == $past(count) + 1'b1
                          || count + 1'b1 == $past(count))); // R6
  AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(count) == CW'(DEPTH)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !lsr_rd |=> overrun); // R7
  AST_IRQ_LEVEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_sel == 2'd0 |-> irq == data_ready); // R8
  AST_IRQ_LEVEL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    trig_sel == 2'd3 && count < CW'(14) |-> !irq); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> count == '0 && !data_ready); // R10
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .lsr_rd(lsr_rd),
  .trig_sel(trig_sel), .count(fifo_count), .overrun(overrun),
  .data_ready(data_ready), .irq(irq)
);

// File: tb/uart_rx_fifo_tb.sv
module uart_rx_fifo_tb;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic [7:0] div_lo = 8'd1, div_hi = 8'd0;
  logic [1:0] word_len = 2'd3, trig_sel = 2'd0;
  logic par_en = 1'b0, par_odd = 1'b0, fifo_clr = 1'b0, rd_en = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, data_ready, overrun, irq;
  logic [4:0] fifo_count;
  int checks = 0, errors = 0, cur_div = 1;

  uart_rx_fifo u_dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    div_lo = d[7:0]; div_hi = d[15:8];
    cur_div = (d == 0) ? 1 : d;
    idle(300);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit pbit,
                      input bit stop_lvl, input int stop_clks);
    int bt;
    bt = 16 * cur_div;
    rxd = 1'b0; idle(bt);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; idle(bt); end
    if (pen) begin rxd = pbit; idle(bt); end
    rxd = stop_lvl; idle(stop_clks);
    rxd = 1'b1; idle(2 * bt);
  endtask

  task automatic send_ok(input logic [7:0] d);
    send(d, 8, 1'b0, 1'b0, 1'b1, 16 * cur_div);
  endtask

  task automatic pop;
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic clear;
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
  endtask

  function automatic int lvl(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  task automatic t_reset;
    chk(fifo_count == 0, "R11 count", fifo_count, 0);
    chk(!data_ready, "R11 data_ready", data_ready, 0);
    chk(!irq, "R11 irq", irq, 0);
    chk(!overrun, "R11 overrun", overrun, 0);
  endtask

  task automatic t_basic;
    send_ok(8'hA5);
    chk(fifo_count == 1, "R6 count after one", fifo_count, 1);
    chk(data_ready, "R9 ready set", data_ready, 1);
    chk(rd_data == 8'hA5, "R3 byte 8 bits", rd_data, 8'hA5);
    chk(!rd_perr && !rd_ferr, "R4 R5 no flags", {rd_perr, rd_ferr}, 0);
    pop();
    chk(fifo_count == 0, "R6 count after pop", fifo_count, 0);
    chk(!data_ready, "R9 ready cleared", data_ready, 0);
  endtask

  task automatic t_order;
    send_ok(8'h11); send_ok(8'h22); send_ok(8'h3C);
    chk(fifo_count == 3, "R6 count three", fifo_count, 3);
    chk(rd_data == 8'h11, "R6 order first", rd_data, 8'h11); pop();
    chk(rd_data == 8'h22, "R6 order second", rd_data, 8'h22); pop();
    chk(rd_data == 8'h3C, "R6 order third", rd_data, 8'h3C); pop();
  endtask

  task automatic t_wordlen;
    word_len = 2'd0;
    send(8'h35, 5, 1'b0, 1'b0, 1'b1, 16);
    chk(rd_data == 8'h15, "R3 five bits", rd_data, 8'h15); pop();
    word_len = 2'd2;
    send(8'hC3, 7, 1'b0, 1'b0, 1'b1, 16);
    chk(rd_data == 8'h43, "R3 seven bits", rd_data, 8'h43); pop();
    word_len = 2'd3;
  endtask

  task automatic t_parity;
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h6B, 8, 1'b1, ^8'h6B, 1'b1, 16);
    chk(!rd_perr && rd_data == 8'h6B, "R4 even good", {rd_perr, rd_data}, 8'h6B); pop();
    send(8'h6B, 8, 1'b1, ~^8'h6B, 1'b1, 16);
    chk(rd_perr, "R4 even bad", rd_perr, 1); pop();
    par_odd = 1'b1; word_len = 2'd2;
    send(8'h25, 7, 1'b1, ~^7'h25, 1'b1, 16);
    chk(!rd_perr && rd_data == 8'h25, "R4 odd good", {rd_perr, rd_data}, 8'h25); pop();
    send(8'h25, 7, 1'b1, ^7'h25, 1'b1, 16);
    chk(rd_perr, "R4 odd bad", rd_perr, 1); pop();
    par_en = 1'b0; par_odd = 1'b0; word_len = 2'd3;
  endtask

  task automatic t_frame;
    send(8'h5E, 8, 1'b0, 1'b0, 1'b0, 12);
    chk(fifo_count == 1, "R5 one entry", fifo_count, 1);
    chk(rd_ferr && rd_data == 8'h5E, "R5 framing flag", {rd_ferr, rd_data}, 9'h15E); pop();
    send_ok(8'h81);
    chk(!rd_ferr && rd_data == 8'h81, "R5 next clean", {rd_ferr, rd_data}, 8'h81); pop();
  endtask

  task automatic t_glitch;
    rxd = 1'b0; idle(4); rxd = 1'b1; idle(200);
    chk(fifo_count == 0, "R2 glitch ignored", fifo_count, 0);
    send_ok(8'h00);
    chk(fifo_count == 1 && rd_data == 8'h00, "R2 real start", {fifo_count, rd_data}, 13'h100); pop();
  endtask

  task automatic t_divisor;
    set_div(3); send_ok(8'hB4);
    chk(fifo_count == 1 && rd_data == 8'hB4, "R1 divisor 3", {fifo_count, rd_data}, 13'h1B4); pop();
    set_div(256); send_ok(8'h4D);
    chk(fifo_count == 1 && rd_data == 8'h4D, "R1 divisor 256", {fifo_count, rd_data}, 13'h14D); pop();
    set_div(0); send_ok(8'hE7);
    chk(fifo_count == 1 && rd_data == 8'hE7, "R1 divisor 0", {fifo_count, rd_data}, 13'h1E7); pop();
    set_div(1);
  endtask

  task automatic t_trigger;
    clear();
    for (int n = 1; n <= 14; n++) begin
      send_ok(8'(n));
      for (int s = 0; s < 4; s++) begin
        trig_sel = 2'(s); @(negedge clk);
        chk(irq == (n >= lvl(2'(s))), "R8 threshold", irq, int'(n >= lvl(2'(s))));
      end
    end
    trig_sel = 2'd1;
  endtask

  task automatic t_overrun;
    send_ok(8'd15); send_ok(8'd16);
    chk(fifo_count == 16 && !overrun, "R7 full no overrun", {fifo_count, overrun}, 32);
    send_ok(8'hEE);
    chk(fifo_count == 16, "R7 count held", fifo_count, 16);
    chk(overrun, "R7 overrun set", overrun, 1);
    chk(rd_data == 8'd1, "R7 head kept", rd_data, 1);
    idle(100);
    chk(overrun, "R7 overrun sticky", overrun, 1);
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    chk(!overrun, "R7 cleared by read", overrun, 0);
    pop();
    chk(rd_data == 8'd2 && fifo_count == 15, "R6 pop after full", {fifo_count, rd_data}, 13'hF02);
  endtask

  task automatic t_clear;
    clear();
    chk(fifo_count == 0 && !data_ready, "R10 cleared", {fifo_count, data_ready}, 0);
    chk(!irq, "R8 irq after clear", irq, 0);
    send_ok(8'h5A);
    chk(fifo_count == 1 && rd_data == 8'h5A, "R10 receive after clear", {fifo_count, rd_data}, 13'h15A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1; idle(5);
    t_reset();
    t_basic();
    t_order();
    t_wordlen();
    t_parity();
    t_frame();
    t_glitch();
    t_divisor();
    t_trigger();
    t_overrun();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule